// File: doc/BRIEF.md
# Three-Operand Integer Adder Unit

This execution unit combines three 32-bit integer operands into one 32-bit result in a single operation. Control comes from a 64-bit instruction word: each operand can be narrowed to one of its 16-bit halves and can be negated, and the partial sum of the first two operands can be moved up or down by 16 bit positions before the third operand is added. A separate variant select says where the operands came from (register file, constant bank or immediate). Only the register variant honours the half selection and the shift; the other two always form a plain sum of the full operands, with negation still applied.

The operands arrive already fetched; the unit does not access a register file or write a destination. A valid strobe accompanies each operation. The result, a result-valid flag and an illegal-encoding flag appear one clock later from a small registered output state machine with three states: ST_IDLE (no result this cycle), ST_RESULT (a legal result is presented) and ST_FAULT (a reserved encoding was seen and zero is presented). From any state, a strobe with a legal encoding moves to ST_RESULT, a strobe with a reserved encoding in the register variant moves to ST_FAULT, and no strobe moves to ST_IDLE. Reset forces ST_IDLE.

Top module: `tri_add_unit`

## Requirements
- R1: Control fields are decoded from the instruction word at these positions: third-operand half select bits 32:31, second-operand half select bits 34:33, first-operand half select bits 36:35, shift mode bits 38:37, negate third operand bit 49, negate second bit 50, negate first bit 51; all other bits have no effect.
- R2: Half select code 0 passes the full 32-bit operand unchanged.
- R3: Half select code 1 keeps the low 16 bits of the operand, zero-extended to 32 bits.
- R4: Half select code 2 takes the high 16 bits of the operand shifted down by 16, zero-extended.
- R5: Negation is two's complement, applies after half selection and before any addition, and applies in every variant.
- R6: Shift mode code 0 yields first + second + third, wrapping modulo 2^32.
- R7: Shift mode code 1 forms first + second as an unsigned 33-bit sum (carry kept), shifts it right by 16, then adds the third operand modulo 2^32.
- R8: Shift mode code 2 yields ((first + second) << 16) + third modulo 2^32.
- R9: Variant select codes 1 (constant) and 2 (immediate) ignore the half select and shift mode fields, including the reserved code 3, yield the plain three-way sum and never raise the illegal flag; code 0 is the register variant.
- R10: In the register variant, code 3 in any half select field or in the shift mode field raises the illegal flag with a result of zero.
- R11: Result, result-valid and illegal flag are registered: result-valid is high exactly in the cycle after a cycle with the valid strobe, the illegal flag is high only together with result-valid, and reset clears all three outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| insn_i | input | 64 | Instruction word holding the control fields |
| variant_i | input | 2 | Operand source variant: 0 register, 1 constant, 2 immediate |
| valid_i | input | 1 | Operation strobe |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| opc_i | input | 32 | Third operand |
| result_o | output | 32 | Registered result |
| valid_o | output | 1 | Result valid, one cycle after the strobe |
| illegal_o | output | 1 | Reserved encoding seen in the register variant |

## Verification
The hardest case to reach is the carry out of the first two operands in the right-shift mode: it only matters when their sum passes 2^32, and a 32-bit partial sum would silently drop it. The stimulus table places operand pairs whose sum is exactly 2^32, and a negated operand whose two's-complement form is near 2^32, so the kept carry lands in bit 16 of the result and a lost carry gives a visibly different value. The order of negation and half selection is likewise only visible with an operand whose upper half is nonzero, so one vector uses such a value with both applied.

// File: rtl/tri_add_pkg.sv
package tri_add_pkg;

    localparam int FLD_HC_LSB = 31;
    localparam int FLD_HB_LSB = 33;
    localparam int FLD_HA_LSB = 35;
    localparam int FLD_MODE_LSB = 37;
    localparam int FLD_NEGC_BIT = 49;
    localparam int FLD_NEGB_BIT = 50;
    localparam int FLD_NEGA_BIT = 51;
    localparam int FLD_CODE_W = 2;

    typedef enum logic [1:0] {
        HT_FULL = 2'd0,
        HT_LOW  = 2'd1,
        HT_HIGH = 2'd2,
        HT_RSVD = 2'd3
    } half_sel_e;

    typedef enum logic [1:0] {
        SM_NONE  = 2'd0,
        SM_RIGHT = 2'd1,
        SM_LEFT  = 2'd2,
        SM_RSVD  = 2'd3
    } shift_mode_e;

    typedef enum logic [1:0] {
        VAR_REG   = 2'd0,
        VAR_CONST = 2'd1,
        VAR_IMM   = 2'd2,
        VAR_SPARE = 2'd3
    } variant_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RESULT = 2'd1,
        ST_FAULT  = 2'd2
    } out_state_e;

    typedef struct packed {
        half_sel_e   half_a;
        half_sel_e   half_b;
        half_sel_e   half_c;
        shift_mode_e mode;
        logic        neg_a;
        logic        neg_b;
        logic        neg_c;
    } ctrl_t;

endpackage

// File: rtl/tri_add_decode.sv
module tri_add_decode
    import tri_add_pkg::*;
#(
    parameter int INSN_W = 64
) (
    input  logic [INSN_W-1:0] insn_i,
    input  logic [1:0]        variant_i,
    output ctrl_t             ctrl_o,
    output logic              illegal_o
);

    variant_e    variant;
    half_sel_e   raw_half_a;
    half_sel_e   raw_half_b;
    half_sel_e   raw_half_c;
    shift_mode_e raw_mode;
    logic        is_reg;

    always_comb begin
        variant    = variant_e'(variant_i);
        raw_half_a = half_sel_e'(insn_i[FLD_HA_LSB +: FLD_CODE_W]);
        raw_half_b = half_sel_e'(insn_i[FLD_HB_LSB +: FLD_CODE_W]);
        raw_half_c = half_sel_e'(insn_i[FLD_HC_LSB +: FLD_CODE_W]);
        raw_mode   = shift_mode_e'(insn_i[FLD_MODE_LSB +: FLD_CODE_W]);
        is_reg     = (variant == VAR_REG);
    end

    always_comb begin
        ctrl_o.neg_a = insn_i[FLD_NEGA_BIT];
        ctrl_o.neg_b = insn_i[FLD_NEGB_BIT];
        ctrl_o.neg_c = insn_i[FLD_NEGC_BIT];
        if (is_reg) begin
            ctrl_o.half_a = raw_half_a;
            ctrl_o.half_b = raw_half_b;
            ctrl_o.half_c = raw_half_c;
            ctrl_o.mode   = raw_mode;
            illegal_o     = (raw_half_a == HT_RSVD) || (raw_half_b == HT_RSVD) ||
                            (raw_half_c == HT_RSVD) || (raw_mode == SM_RSVD);
        end else begin
            ctrl_o.half_a = HT_FULL;
            ctrl_o.half_b = HT_FULL;
            ctrl_o.half_c = HT_FULL;
            ctrl_o.mode   = SM_NONE;
            illegal_o     = 1'b0;
        end
    end

endmodule

// File: rtl/tri_add_opsel.sv
module tri_add_opsel
    import tri_add_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HALF_W = DATA_W / 2
) (
    input  logic [DATA_W-1:0] value_i,
    input  half_sel_e         half_i,
    input  logic              neg_i,
    output logic [DATA_W-1:0] value_o
);

    localparam int UPPER_W = DATA_W - HALF_W;

    logic [DATA_W-1:0] narrowed;

    always_comb begin
        unique case (half_i)
            HT_LOW:  narrowed = {{UPPER_W{1'b0}}, value_i[HALF_W-1:0]};
            HT_HIGH: narrowed = value_i >> HALF_W;
            HT_FULL: narrowed = value_i;
            HT_RSVD: narrowed = value_i;
        endcase
    end

    always_comb begin
        if (neg_i) begin
            value_o = DATA_W'(0) - narrowed;
        end else begin
            value_o = narrowed;
        end
    end

endmodule

// File: rtl/tri_add_core.sv
module tri_add_core
    import tri_add_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HALF_W = DATA_W / 2
) (
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [DATA_W-1:0] opc_i,
    input  shift_mode_e       mode_i,
    output logic [DATA_W-1:0] sum_o
);

    localparam int WIDE_W = DATA_W + 1;

    logic [WIDE_W-1:0] partial;
    logic [DATA_W-1:0] moved;

    always_comb begin
        partial = {1'b0, opa_i} + {1'b0, opb_i};
    end

    always_comb begin
        unique case (mode_i)
            SM_RIGHT: moved = DATA_W'(partial >> HALF_W);
            SM_LEFT:  moved = partial[DATA_W-1:0] << HALF_W;
            SM_NONE:  moved = partial[DATA_W-1:0];
            SM_RSVD:  moved = partial[DATA_W-1:0];
        endcase
    end

    always_comb begin
        sum_o = moved + opc_i;
    end

endmodule

// File: rtl/tri_add_unit.sv
module tri_add_unit
    import tri_add_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HALF_W = DATA_W / 2,
    parameter int INSN_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INSN_W-1:0] insn_i,
    input  logic [1:0]        variant_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [DATA_W-1:0] opc_i,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o,
    output logic              illegal_o
);

    localparam int NUM_OPS = 3;

    ctrl_t             ctrl;
    logic              bad_code;
    logic [DATA_W-1:0] raw_op  [NUM_OPS];
    logic [DATA_W-1:0] prep_op [NUM_OPS];
    half_sel_e         op_half [NUM_OPS];
    logic              op_neg  [NUM_OPS];
    logic [DATA_W-1:0] sum;
    out_state_e        state_q;
    out_state_e        state_d;
    logic [DATA_W-1:0] result_q;

    tri_add_decode #(
        .INSN_W(INSN_W)
    ) decode_i (
        .insn_i   (insn_i),
        .variant_i(variant_i),
        .ctrl_o   (ctrl),
        .illegal_o(bad_code)
    );

    always_comb begin
        raw_op[0]  = opa_i;
        raw_op[1]  = opb_i;
        raw_op[2]  = opc_i;
        op_half[0] = ctrl.half_a;
        op_half[1] = ctrl.half_b;
        op_half[2] = ctrl.half_c;
        op_neg[0]  = ctrl.neg_a;
        op_neg[1]  = ctrl.neg_b;
        op_neg[2]  = ctrl.neg_c;
    end

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_opsel
        tri_add_opsel #(
            .DATA_W(DATA_W),
            .HALF_W(HALF_W)
        ) opsel_i (
            .value_i(raw_op[g]),
            .half_i (op_half[g]),
            .neg_i  (op_neg[g]),
            .value_o(prep_op[g])
        );
    end

    tri_add_core #(
        .DATA_W(DATA_W),
        .HALF_W(HALF_W)
    ) core_i (
        .opa_i (prep_op[0]),
        .opb_i (prep_op[1]),
        .opc_i (prep_op[2]),
        .mode_i(ctrl.mode),
        .sum_o (sum)
    );

    // Next-state logic: every state reacts to the strobe the same way.
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_RESULT, ST_FAULT: begin
                if (valid_i) begin
                    state_d = bad_code ? ST_FAULT : ST_RESULT;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Result register: captured with the strobe, zero on a fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (valid_i) begin
            result_q <= bad_code ? '0 : sum;
        end
    end

    // Output decode from the state.
    always_comb begin
        valid_o   = 1'b0;
        illegal_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                valid_o   = 1'b0;
                illegal_o = 1'b0;
            end
            ST_RESULT: begin
                valid_o   = 1'b1;
                illegal_o = 1'b0;
            end
            ST_FAULT: begin
                valid_o   = 1'b1;
                illegal_o = 1'b1;
            end
            default: begin
                valid_o   = 1'b0;
                illegal_o = 1'b0;
            end
        endcase
        result_o = result_q;
    end

    // R11: result-valid follows the strobe by one cycle.
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);

    // R11: no strobe, no result-valid in the next cycle.
    a_r11_idle_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !valid_o);

    // R10 and R11: a fault presents zero and is flagged with valid.
    a_r10_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (valid_o && result_o == '0));

    // R10: reserved shift mode in the register variant is flagged.
    a_r10_reserved_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && variant_i == 2'd0 && insn_i[FLD_MODE_LSB +: FLD_CODE_W] == 2'd3)
        |=> illegal_o);

    // R9: constant and immediate variants never raise the flag.
    a_r9_alt_variant_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && variant_i != 2'd0) |=> !illegal_o);

    // R8: after a left shift of the partial sum, the low half comes from the third operand alone.
    a_r8_left_low_half: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && variant_i == 2'd0 &&
         insn_i[FLD_MODE_LSB +: FLD_CODE_W] == 2'd2 &&
         insn_i[FLD_HC_LSB +: FLD_CODE_W] == 2'd0 &&
         insn_i[FLD_HB_LSB +: FLD_CODE_W] != 2'd3 &&
         insn_i[FLD_HA_LSB +: FLD_CODE_W] != 2'd3 &&
         !insn_i[FLD_NEGC_BIT])
        |=> (result_o[HALF_W-1:0] == $past(opc_i[HALF_W-1:0])));

endmodule

// File: tb/tri_add_unit_tb_top.sv
module tri_add_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 19;

    typedef struct packed {
        logic [1:0]  vsel;
        logic [1:0]  ha;
        logic [1:0]  hb;
        logic [1:0]  hc;
        logic [1:0]  md;
        logic        na;
        logic        nb;
        logic        nc;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] c;
        logic [31:0] exp;
        logic        ill;
        logic [3:0]  req;
    } vec_t;

    // vsel ha hb hc md na nb nc a b c expected illegal requirement
    localparam vec_t VECS [NV] = '{
        '{2'd0,2'd0,2'd0,2'd0,2'd0,1'b0,1'b0,1'b0,32'h00000001,32'h00000002,32'h00000003,32'h00000006,1'b0,4'd6},  // R6
        '{2'd0,2'd0,2'd0,2'd0,2'd0,1'b0,1'b0,1'b0,32'hFFFFFFFF,32'h00000002,32'h00000000,32'h00000001,1'b0,4'd6},  // R6 wrap
        '{2'd0,2'd1,2'd0,2'd0,2'd0,1'b0,1'b0,1'b0,32'h12345678,32'h00000000,32'h00000000,32'h00005678,1'b0,4'd3},  // R3
        '{2'd0,2'd0,2'd2,2'd0,2'd0,1'b0,1'b0,1'b0,32'h00000000,32'hABCD1234,32'h00000001,32'h0000ABCE,1'b0,4'd4},  // R4
        '{2'd0,2'd0,2'd0,2'd1,2'd0,1'b0,1'b0,1'b0,32'h00000010,32'h00000020,32'hFFFF0001,32'h00000031,1'b0,4'd3},  // R3 on C
        '{2'd0,2'd0,2'd0,2'd0,2'd0,1'b1,1'b0,1'b0,32'h00000005,32'h00000003,32'h00000000,32'hFFFFFFFE,1'b0,4'd5},  // R5
        '{2'd0,2'd1,2'd0,2'd0,2'd0,1'b1,1'b0,1'b0,32'h00010002,32'h00000000,32'h00000000,32'hFFFFFFFE,1'b0,4'd5},  // R5 order
        '{2'd0,2'd0,2'd0,2'd0,2'd1,1'b0,1'b0,1'b0,32'hFFFF0000,32'h00010000,32'h00000005,32'h00010005,1'b0,4'd7},  // R7 carry
        '{2'd0,2'd0,2'd0,2'd0,2'd1,1'b0,1'b0,1'b0,32'h00030000,32'h00050000,32'h00000100,32'h00000108,1'b0,4'd7},  // R7
        '{2'd0,2'd0,2'd0,2'd0,2'd2,1'b0,1'b0,1'b0,32'h00000001,32'h00000002,32'h00000007,32'h00030007,1'b0,4'd8},  // R8
        '{2'd0,2'd0,2'd0,2'd0,2'd2,1'b0,1'b0,1'b0,32'h00018000,32'h00000000,32'h80000000,32'h00000000,1'b0,4'd8},  // R8 wrap
        '{2'd1,2'd1,2'd0,2'd0,2'd1,1'b0,1'b0,1'b0,32'h12345678,32'h00000001,32'h00000001,32'h1234567A,1'b0,4'd9},  // R9 const
        '{2'd2,2'd3,2'd3,2'd3,2'd3,1'b0,1'b0,1'b0,32'h0000000A,32'h0000000A,32'h0000000A,32'h0000001E,1'b0,4'd9},  // R9 imm reserved
        '{2'd1,2'd0,2'd0,2'd0,2'd0,1'b0,1'b0,1'b1,32'h00000010,32'h00000000,32'h00000001,32'h0000000F,1'b0,4'd5},  // R5 const negate
        '{2'd0,2'd3,2'd0,2'd0,2'd0,1'b0,1'b0,1'b0,32'h00000001,32'h00000001,32'h00000001,32'h00000000,1'b1,4'd10}, // R10 half A
        '{2'd0,2'd0,2'd0,2'd0,2'd3,1'b0,1'b0,1'b0,32'h00000001,32'h00000001,32'h00000001,32'h00000000,1'b1,4'd10}, // R10 mode
        '{2'd0,2'd0,2'd0,2'd3,2'd0,1'b0,1'b0,1'b0,32'h00000001,32'h00000001,32'h00000001,32'h00000000,1'b1,4'd10}, // R10 half C
        '{2'd0,2'd0,2'd0,2'd0,2'd1,1'b1,1'b0,1'b0,32'h00000001,32'h00000000,32'h00000000,32'h0000FFFF,1'b0,4'd7},  // R7 negated
        '{2'd0,2'd0,2'd0,2'd0,2'd0,1'b0,1'b0,1'b0,32'hFFFF0000,32'h0000FFFF,32'h00000000,32'hFFFFFFFF,1'b0,4'd2}   // R2
    };

    logic        clk;
    logic        rst_n;
    logic [63:0] insn;
    logic [1:0]  vsel;
    logic        valid;
    logic [31:0] opa;
    logic [31:0] opb;
    logic [31:0] opc;
    logic [31:0] result;
    logic        res_valid;
    logic        res_illegal;

    int checks;
    int failures;

    tri_add_unit dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .insn_i   (insn),
        .variant_i(vsel),
        .valid_i  (valid),
        .opa_i    (opa),
        .opb_i    (opb),
        .opc_i    (opc),
        .result_o (result),
        .valid_o  (res_valid),
        .illegal_o(res_illegal)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // R1: unrelated bits are all ones so only the named fields can matter.
    function automatic logic [63:0] build_insn(vec_t v);
        logic [63:0] w;
        w = '1;
        w[32:31] = v.hc;
        w[34:33] = v.hb;
        w[36:35] = v.ha;
        w[38:37] = v.md;
        w[49] = v.nc;
        w[50] = v.nb;
        w[51] = v.na;
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        checks = 0;
        failures = 0;
        rst_n = 1'b0;
        valid = 1'b0;
        insn = '0;
        vsel = 2'd0;
        opa = '0;
        opb = '0;
        opc = '0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 reset valid", 32'(res_valid), 32'd0);
        check("R11 reset illegal", 32'(res_illegal), 32'd0);
        check("R11 reset result", result, 32'd0);
        rst_n = 1'b1;

        // Table walk, one operation per cycle, back to back.
        for (int i = 0; i < NV; i++) begin
            insn = build_insn(VECS[i]);
            vsel = VECS[i].vsel;
            opa = VECS[i].a;
            opb = VECS[i].b;
            opc = VECS[i].c;
            valid = 1'b1;
            @(negedge clk);
            check($sformatf("R%0d vector %0d result", VECS[i].req, i), result, VECS[i].exp);
            check($sformatf("R%0d vector %0d illegal", VECS[i].req, i), 32'(res_illegal), 32'(VECS[i].ill));
            check($sformatf("R11 vector %0d valid", i), 32'(res_valid), 32'd1);
        end

        // R11: strobe low, valid and illegal drop the next cycle.
        valid = 1'b0;
        insn = build_insn(VECS[14]);
        vsel = 2'd0;
        @(negedge clk);
        check("R11 no strobe valid", 32'(res_valid), 32'd0);
        check("R11 no strobe illegal", 32'(res_illegal), 32'd0);

        // R1: a field bit moved outside the named positions has no effect.
        insn = '0;
        insn[30] = 1'b1;
        insn[39] = 1'b1;
        insn[48] = 1'b1;
        insn[52] = 1'b1;
        vsel = 2'd0;
        opa = 32'h00020003;
        opb = 32'h00000004;
        opc = 32'h00000005;
        valid = 1'b1;
        @(negedge clk);
        check("R1 neighbour bits ignored", result, 32'h0002000C);
        check("R1 neighbour bits legal", 32'(res_illegal), 32'd0);

        // R11: reset in the same cycle as a strobe clears the outputs.
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 reset over strobe valid", 32'(res_valid), 32'd0);
        check("R11 reset over strobe result", result, 32'd0);
        valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 after reset valid", 32'(res_valid), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule